// File: doc/BRIEF.md
# DRAM Read Burst Return Scheduler

This block is a cycle-level model of the data-return side of a double-data-rate DRAM read. Each READ command carries a bank, a starting column, an auto-precharge flag and a burst-chop flag. The block holds the command for a programmable read latency, which is the sum of an additive term and a CAS term. It then plays the burst out on a bus that carries two data slots per clock, one for the rising half and one for the falling half. For each slot it reports the column of the element that occupies it.

Around the data it drives a per-cycle output-enable. That enable covers a one-clock strobe preamble and a one-clock strobe postamble. The block also pulses a flag in the first cycle after the bus is released to high impedance. When two full bursts are spaced at the minimum command gap, they merge into an unbroken stream with no preamble or postamble between them. A chopped burst followed by the next command at the minimum gap leaves a two-clock hole. The postamble and the preamble fill that hole, so the bus stays driven.

At the last data cycle of each burst the block reports the bank. It also reports whether the row was closed by auto-precharge or left open. A READ that arrives too soon after the previous accepted READ is dropped and a protocol-error flag is raised.

Top module: `rdret_top`

## Requirements
- R1: The first data cycle of an accepted READ comes exactly AL+CL cycles after the cycle in which the command was presented. AL and CL are held in mode registers that reset to AL=0 and CL=8.
- R2: A full burst occupies 4 consecutive data cycles and delivers 8 elements. In every data cycle, data_valid=1 and dqs_hi=1. The rise slot carries element 2b and the fall slot carries element 2b+1, where b is the data cycle within the burst. Element i has column {col[9:3], (col[2:0]+i) mod 8}.
- R3: A chopped burst (rd_chop=1) occupies 2 data cycles and delivers 4 elements. Element i has column {col[9:2], (col[1:0]+i) mod 4}.
- R4: In the cycle before the first data cycle of a burst that does not follow on from an earlier burst, dq_oe=1, dqs_hi=0 and data_valid=0 (preamble).
- R5: In the cycle after the last data cycle, when no data follows, dq_oe=1, dqs_hi=0 and data_valid=0 (postamble). bus_hiz is 1 for exactly the first cycle in which dq_oe is 0 after having been 1.
- R6: A full burst followed by a READ exactly 4 cycles later yields data cycles with no gap, and no preamble or postamble between the bursts.
- R7: A chopped burst followed by a READ 4 cycles later leaves two non-data cycles between the bursts, a postamble and then a preamble. dq_oe stays 1 through both and bus_hiz stays 0.
- R8: In the last data cycle of a burst, done_bank equals the command's bank. ap_done=1 if the auto-precharge flag was set, otherwise open_done=1. At all other times both are 0.
- R9: A READ presented fewer than 4 cycles after the last accepted READ produces no data, and proto_err is 1 in the following cycle for one cycle.
- R10: A mode write is taken only when no READ is in flight and no postamble is pending. Otherwise it is ignored and later READs keep the old latency. A taken write affects READs from the next cycle on, while a READ in the same cycle uses the old latency.
- R11: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_al | input | 3 | Additive latency to load |
| mode_cl | input | 5 | CAS latency to load |
| rd_valid | input | 1 | READ command present this cycle |
| rd_bank | input | 3 | Bank of the READ |
| rd_col | input | 10 | Starting column of the READ |
| rd_ap | input | 1 | Auto-precharge requested |
| rd_chop | input | 1 | Burst chop to 4 elements |
| dq_oe | output | 1 | Bus driven this cycle (preamble, data or postamble) |
| dqs_hi | output | 1 | Strobe high in the first half of this cycle |
| data_valid | output | 1 | Both data slots carry elements this cycle |
| rise_col | output | 10 | Column of the rise-slot element |
| fall_col | output | 10 | Column of the fall-slot element |
| proto_err | output | 1 | READ rejected in the previous cycle |
| bus_hiz | output | 1 | Bus returned to high impedance this cycle |
| ap_done | output | 1 | Burst ends with the row precharged |
| open_done | output | 1 | Burst ends with the row left open |
| done_bank | output | 3 | Bank of the burst that ends this cycle |

## Verification
A wrong entry in the latency line shows up as data that appears at the wrong cycle, so the error is visible within AL+CL cycles of the command. A beat counter that drifts shows up in the same burst as a wrong column order or a wrong burst length. Because every command in the bench is scored cycle by cycle against an arithmetic timeline, a wrong latency register is caught at the first read after the mode write. A wrong command-gap counter shows as a missing or extra proto_err one cycle after the offending READ, and as data that should not exist RL cycles later. Stale last-beat state shows as a missing postamble or a misplaced bus_hiz in the cycle right after the burst.

// File: rtl/rdret_pkg.sv
package rdret_pkg;
  localparam int COL_W  = 10;
  localparam int BANK_W = 3;
  localparam int AL_W   = 3;
  localparam int CL_W   = 5;
  localparam int MAX_RL = 40;
  localparam int RL_MIN = 2;
  localparam int RL_W   = $clog2(MAX_RL + 1);
  localparam int CCD    = 4;
  localparam int GAP_W  = $clog2(CCD + 1);

  typedef struct packed {
    logic              vld;
    logic              chop;
    logic              ap;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } rd_ent_t;

  // read latency from the two mode terms, clamped to the line depth
  function automatic logic [RL_W-1:0] rl_calc(input logic [AL_W-1:0] al,
                                               input logic [CL_W-1:0] cl);
    int s;
    s = int'(al) + int'(cl);
    if (s < RL_MIN) s = RL_MIN;
    if (s > MAX_RL) s = MAX_RL;
    return RL_W'(s);
  endfunction

  // index of the final data cycle of a burst
  function automatic logic [1:0] last_beat(input logic chop);
    return chop ? 2'd1 : 2'd3;
  endfunction

  // column of element idx, wrapping inside the aligned group
  function automatic logic [COL_W-1:0] elem_col(input logic [COL_W-1:0] base,
                                                input logic chop,
                                                input logic [2:0] idx);
    logic [COL_W-1:0] r;
    r = base;
    if (chop) r[1:0] = base[1:0] + idx[1:0];
    else      r[2:0] = base[2:0] + idx;
    return r;
  endfunction
endpackage

// File: rtl/rdret_mode.sv
module rdret_mode
  import rdret_pkg::*;
#(
  parameter int AL_RST = 0,
  parameter int CL_RST = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            idle,
  input  logic [AL_W-1:0] al_in,
  input  logic [CL_W-1:0] cl_in,
  output logic            take,
  output logic [RL_W-1:0] rl
);
  logic [AL_W-1:0] al_q;
  logic [CL_W-1:0] cl_q;

  assign take = wr & idle;
  assign rl   = rl_calc(al_q, cl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q <= AL_W'(AL_RST);
      cl_q <= CL_W'(CL_RST);
    end else if (take) begin
      al_q <= al_in;
      cl_q <= cl_in;
    end
  end
endmodule

// File: rtl/rdret_gate.sv
module rdret_gate
  import rdret_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic take,
  output logic err
);
  logic [GAP_W-1:0] since_q;
  logic             gap_ok;

  assign gap_ok = (int'(since_q) >= CCD);
  assign take   = req & gap_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= GAP_W'(CCD);
      err     <= 1'b0;
    end else begin
      err <= req & ~gap_ok;
      if (take)        since_q <= GAP_W'(1);
      else if (!gap_ok) since_q <= since_q + GAP_W'(1);
    end
  end
endmodule

// File: rtl/rdret_delay.sv
module rdret_delay
  import rdret_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  rd_ent_t         ent_in,
  input  logic [RL_W-1:0] rl,
  output rd_ent_t         head,
  output logic            next_vld,
  output logic            any_vld
);
  rd_ent_t line_q [MAX_RL];

  assign head     = line_q[0];
  assign next_vld = line_q[1].vld;

  always_comb begin
    any_vld = 1'b0;
    for (int k = 0; k < MAX_RL; k++) any_vld = any_vld | line_q[k].vld;
  end

  // slot k reaches the head k edges later; a command lands in slot rl-1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_RL; k++) line_q[k] <= '0;
    end else begin
      for (int k = 0; k < MAX_RL; k++) begin
        if (load && int'(rl) == k + 1) line_q[k] <= ent_in;
        else if (k == MAX_RL - 1)      line_q[k] <= '0;
        else                           line_q[k] <= line_q[(k + 1) % MAX_RL];
      end
    end
  end
endmodule

// File: rtl/rdret_beats.sv
module rdret_beats
  import rdret_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rd_ent_t           head,
  output logic              act,
  output logic              data_cyc,
  output logic              last_cyc,
  output logic [COL_W-1:0]  rcol,
  output logic [COL_W-1:0]  fcol,
  output logic [BANK_W-1:0] cur_bank,
  output logic              cur_ap
);
  logic [1:0]        beat_q;
  logic              chop_q;
  logic              ap_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;

  logic [1:0]        bsel;
  logic              cur_chop;
  logic [COL_W-1:0]  cur_col;

  always_comb begin
    if (head.vld) begin
      bsel     = 2'd0;
      cur_chop = head.chop;
      cur_col  = head.col;
      cur_bank = head.bank;
      cur_ap   = head.ap;
    end else begin
      bsel     = beat_q;
      cur_chop = chop_q;
      cur_col  = col_q;
      cur_bank = bank_q;
      cur_ap   = ap_q;
    end
    data_cyc = head.vld | act;
    last_cyc = data_cyc & (bsel == last_beat(cur_chop));
    rcol = data_cyc ? elem_col(cur_col, cur_chop, {bsel, 1'b0}) : '0;
    fcol = data_cyc ? elem_col(cur_col, cur_chop, {bsel, 1'b1}) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      beat_q <= '0;
      chop_q <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
    end else if (head.vld) begin
      act    <= 1'b1;
      beat_q <= 2'd1;
      chop_q <= head.chop;
      ap_q   <= head.ap;
      bank_q <= head.bank;
      col_q  <= head.col;
    end else if (act) begin
      if (beat_q == last_beat(chop_q)) act <= 1'b0;
      beat_q <= beat_q + 2'd1;
    end
  end
endmodule

// File: rtl/rdret_top.sv
module rdret_top
  import rdret_pkg::*;
#(
  parameter int AL_RST = 0,
  parameter int CL_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [AL_W-1:0]   mode_al,
  input  logic [CL_W-1:0]   mode_cl,
  input  logic              rd_valid,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              rd_ap,
  input  logic              rd_chop,
  output logic              dq_oe,
  output logic              dqs_hi,
  output logic              data_valid,
  output logic [COL_W-1:0]  rise_col,
  output logic [COL_W-1:0]  fall_col,
  output logic              proto_err,
  output logic              bus_hiz,
  output logic              ap_done,
  output logic              open_done,
  output logic [BANK_W-1:0] done_bank
);
  // named internal events, also observed by the bound checker
  logic              cmd_take;
  logic              mode_take;
  logic [RL_W-1:0]   rl;
  logic              idle;
  rd_ent_t           ent_in;
  rd_ent_t           head;
  logic              next_vld;
  logic              any_vld;
  logic              act;
  logic              data_cyc;
  logic              last_cyc;
  logic              last_q;
  logic              oe_q;
  logic              pre_cyc;
  logic              post_cyc;
  logic [BANK_W-1:0] cur_bank;
  logic              cur_ap;

  assign idle   = ~any_vld & ~act & ~last_q;
  assign ent_in = '{vld: 1'b1, chop: rd_chop, ap: rd_ap, bank: rd_bank, col: rd_col};

  rdret_mode #(.AL_RST(AL_RST), .CL_RST(CL_RST)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .idle(idle),
    .al_in(mode_al), .cl_in(mode_cl), .take(mode_take), .rl(rl)
  );

  rdret_gate u_gate (
    .clk(clk), .rst_n(rst_n), .req(rd_valid), .take(cmd_take), .err(proto_err)
  );

  rdret_delay u_delay (
    .clk(clk), .rst_n(rst_n), .load(cmd_take), .ent_in(ent_in), .rl(rl),
    .head(head), .next_vld(next_vld), .any_vld(any_vld)
  );

  rdret_beats u_beats (
    .clk(clk), .rst_n(rst_n), .head(head), .act(act), .data_cyc(data_cyc),
    .last_cyc(last_cyc), .rcol(rise_col), .fcol(fall_col),
    .cur_bank(cur_bank), .cur_ap(cur_ap)
  );

  assign pre_cyc    = next_vld & ~data_cyc;
  assign post_cyc   = last_q & ~data_cyc;
  assign data_valid = data_cyc;
  assign dqs_hi     = data_cyc;
  assign dq_oe      = data_cyc | pre_cyc | post_cyc;
  assign bus_hiz    = oe_q & ~dq_oe;
  assign ap_done    = last_cyc & cur_ap;
  assign open_done  = last_cyc & ~cur_ap;
  assign done_bank  = last_cyc ? cur_bank : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      last_q <= last_cyc;
      oe_q   <= dq_oe;
    end
  end
endmodule

// File: rtl/rdret_props.sv
module rdret_props (
  input logic clk,
  input logic rst_n,
  input logic cmd_take,
  input logic rd_valid,
  input logic proto_err,
  input logic dq_oe,
  input logic dqs_hi,
  input logic data_valid,
  input logic bus_hiz,
  input logic ap_done,
  input logic open_done
);
  p_preamble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(dq_oe) && !$past(dqs_hi));

  p_postamble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_valid) |-> dq_oe && !dqs_hi);

  p_hiz_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hiz |-> $past(dq_oe) && !dq_oe);

  p_ccd_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |-> !$past(cmd_take) && !$past(cmd_take, 2) && !$past(cmd_take, 3));

  p_reject_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(rd_valid) && !$past(cmd_take));

  p_done_in_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_done || open_done) |-> data_valid && !(ap_done && open_done));
endmodule

bind rdret_top rdret_props u_props (
  .clk(clk), .rst_n(rst_n), .cmd_take(cmd_take), .rd_valid(rd_valid),
  .proto_err(proto_err), .dq_oe(dq_oe), .dqs_hi(dqs_hi),
  .data_valid(data_valid), .bus_hiz(bus_hiz), .ap_done(ap_done),
  .open_done(open_done)
);

// File: tb/rdret_top_test.sv
module rdret_top_test;
  localparam int CLK_T = 10;
  localparam int NC    = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [2:0] mode_al = '0;
  logic [4:0] mode_cl = '0;
  logic rd_valid = 1'b0;
  logic [2:0] rd_bank = '0;
  logic [9:0] rd_col = '0;
  logic rd_ap = 1'b0;
  logic rd_chop = 1'b0;
  logic dq_oe, dqs_hi, data_valid, proto_err, bus_hiz, ap_done, open_done;
  logic [9:0] rise_col, fall_col;
  logic [2:0] done_bank;

  int total = 0;
  int bad = 0;

  // stimulus plan and expected timeline, indexed by cycle
  logic       p_v [NC];
  logic       p_ch[NC];
  logic       p_ap[NC];
  logic       p_ld[NC];
  logic [9:0] p_col[NC];
  logic [2:0] p_bk[NC];
  logic [2:0] p_al[NC];
  logic [4:0] p_cl[NC];
  logic       e_dv[NC];
  logic       e_oe[NC];
  logic       e_hz[NC];
  logic       e_er[NC];
  logic       e_ap[NC];
  logic       e_op[NC];
  logic [9:0] e_rc[NC];
  logic [9:0] e_fc[NC];
  logic [2:0] e_bk[NC];

  always #(CLK_T / 2) clk = ~clk;

  rdret_top uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_al(mode_al),
    .mode_cl(mode_cl), .rd_valid(rd_valid), .rd_bank(rd_bank),
    .rd_col(rd_col), .rd_ap(rd_ap), .rd_chop(rd_chop), .dq_oe(dq_oe),
    .dqs_hi(dqs_hi), .data_valid(data_valid), .rise_col(rise_col),
    .fall_col(fall_col), .proto_err(proto_err), .bus_hiz(bus_hiz),
    .ap_done(ap_done), .open_done(open_done), .done_bank(done_bank)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] want_col(input logic [9:0] c, input logic ch, input int i);
    logic [9:0] m;
    m = ch ? 10'd3 : 10'd7;
    return (c & ~m) | ((c + 10'(i)) & m);
  endfunction

  task automatic clear_plan();
    for (int c = 0; c < NC; c++) begin
      p_v[c] = 0; p_ch[c] = 0; p_ap[c] = 0; p_ld[c] = 0;
      p_col[c] = '0; p_bk[c] = '0; p_al[c] = '0; p_cl[c] = '0;
    end
  endtask

  task automatic add_rd(input int c, input logic [9:0] col, input logic [2:0] bk,
                        input logic ap, input logic ch);
    p_v[c] = 1; p_col[c] = col; p_bk[c] = bk; p_ap[c] = ap; p_ch[c] = ch;
  endtask

  task automatic add_ld(input int c, input int al, input int cl);
    p_ld[c] = 1; p_al[c] = 3'(al); p_cl[c] = 5'(cl);
  endtask

  task automatic build_expect(input int n);
    int cur_rl, last_acc, busy_until, len, st;
    bit ld_ok;
    cur_rl = 8; last_acc = -100; busy_until = -1;
    for (int c = 0; c < NC; c++) begin
      e_dv[c] = 0; e_oe[c] = 0; e_hz[c] = 0; e_er[c] = 0; e_ap[c] = 0; e_op[c] = 0;
      e_rc[c] = '0; e_fc[c] = '0; e_bk[c] = '0;
    end
    for (int c = 0; c < n; c++) begin
      ld_ok = p_ld[c] && (c > busy_until);
      if (p_v[c]) begin
        if (c - last_acc >= 4) begin
          last_acc = c;
          len = p_ch[c] ? 2 : 4;
          st = c + cur_rl;
          if (st + len > busy_until) busy_until = st + len;
          for (int b = 0; b < len; b++) begin
            if (st + b < NC) begin
              e_dv[st + b] = 1;
              e_rc[st + b] = want_col(p_col[c], p_ch[c], 2 * b);
              e_fc[st + b] = want_col(p_col[c], p_ch[c], 2 * b + 1);
              if (b == len - 1) begin
                e_ap[st + b] = p_ap[c];
                e_op[st + b] = !p_ap[c];
                e_bk[st + b] = p_bk[c];
              end
            end
          end
        end else if (c + 1 < NC) begin
          e_er[c + 1] = 1;
        end
      end
      if (ld_ok) cur_rl = int'(p_al[c]) + int'(p_cl[c]);
    end
    for (int c = 0; c < NC; c++)
      e_oe[c] = e_dv[c] | ((c + 1 < NC) && e_dv[c + 1]) | ((c > 0) && e_dv[c - 1]);
    for (int c = 1; c < NC; c++)
      e_hz[c] = e_oe[c - 1] & ~e_oe[c];
  endtask

  task automatic run(input string tag, input int n);
    build_expect(n);
    rst_n = 1'b0; mode_wr = 0; rd_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state of every output
    chk("R11", "reset outputs",
        int'({dq_oe, dqs_hi, data_valid, proto_err, bus_hiz, ap_done, open_done}) +
        int'(rise_col) + int'(fall_col) + int'(done_bank), 0);
    rst_n = 1'b1;
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk(tag, "data_valid", data_valid, e_dv[c]);
      chk(tag, "dqs_hi", dqs_hi, e_dv[c]);
      chk(tag, "dq_oe", dq_oe, e_oe[c]);
      chk(tag, "bus_hiz", bus_hiz, e_hz[c]);
      chk(tag, "proto_err", proto_err, e_er[c]);
      chk(tag, "ap_done", ap_done, e_ap[c]);
      chk(tag, "open_done", open_done, e_op[c]);
      if (e_dv[c]) begin
        chk(tag, "rise_col", rise_col, e_rc[c]);
        chk(tag, "fall_col", fall_col, e_fc[c]);
      end
      if (e_ap[c] || e_op[c]) chk(tag, "done_bank", done_bank, e_bk[c]);
      rd_valid = p_v[c]; rd_col = p_col[c]; rd_bank = p_bk[c];
      rd_ap = p_ap[c]; rd_chop = p_ch[c];
      mode_wr = p_ld[c]; mode_al = p_al[c]; mode_cl = p_cl[c];
    end
    rd_valid = 0; mode_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 R2 R8: isolated full bursts, every start offset in the group
    clear_plan();
    for (int s = 0; s < 8; s++)
      add_rd(2 + 20 * s, 10'(((s * 13) << 3) | s), 3'(s), s[0], 1'b0);
    run("R1 R2 R4 R5 R8", 180);

    // R3 R8: isolated chopped bursts
    clear_plan();
    for (int s = 0; s < 8; s++)
      add_rd(2 + 16 * s, 10'(((s * 7) << 3) | s), 3'(7 - s), ~s[0], 1'b1);
    run("R3 R8", 150);

    // R6: seamless full bursts at the minimum gap
    clear_plan();
    add_rd(5, 10'd101, 3'd1, 1'b0, 1'b0);
    add_rd(9, 10'd206, 3'd2, 1'b1, 1'b0);
    add_rd(13, 10'd315, 3'd3, 1'b0, 1'b0);
    add_rd(17, 10'd420, 3'd4, 1'b1, 1'b0);
    add_rd(40, 10'd3, 3'd5, 1'b1, 1'b0);
    run("R6", 70);

    // R7: chopped bursts at the minimum gap, then chop followed by full
    clear_plan();
    add_rd(5, 10'd17, 3'd0, 1'b1, 1'b1);
    add_rd(9, 10'd42, 3'd6, 1'b0, 1'b1);
    add_rd(13, 10'd63, 3'd2, 1'b1, 1'b1);
    add_rd(30, 10'd510, 3'd1, 1'b0, 1'b1);
    add_rd(34, 10'd777, 3'd7, 1'b1, 1'b0);
    run("R7", 60);

    // R9: commands too close to the last accepted one
    clear_plan();
    add_rd(5, 10'd8, 3'd1, 1'b0, 1'b0);
    add_rd(7, 10'd9, 3'd2, 1'b0, 1'b0);
    add_rd(8, 10'd10, 3'd3, 1'b0, 1'b0);
    add_rd(9, 10'd11, 3'd4, 1'b1, 1'b0);
    add_rd(12, 10'd12, 3'd5, 1'b0, 1'b1);
    add_rd(14, 10'd13, 3'd6, 1'b1, 1'b1);
    run("R9", 40);

    // R1 R10: mode writes when idle, when busy, and alongside a READ
    clear_plan();
    add_ld(2, 2, 5);
    add_rd(10, 10'd55, 3'd1, 1'b0, 1'b0);
    add_ld(15, 1, 9);
    add_rd(40, 10'd66, 3'd2, 1'b1, 1'b0);
    add_ld(60, 0, 5);
    add_rd(65, 10'd77, 3'd3, 1'b0, 1'b1);
    add_ld(90, 7, 31);
    add_rd(95, 10'd88, 3'd4, 1'b1, 1'b1);
    add_ld(150, 0, 6);
    add_rd(150, 10'd99, 3'd5, 1'b0, 1'b0);
    add_rd(160, 10'd111, 3'd6, 1'b1, 1'b0);
    run("R1 R10", 200);

    // R1: latency sweep over CAS and additive settings
    for (int al = 0; al < 4; al += 3) begin
      for (int cl = 5; cl <= 11; cl++) begin
        clear_plan();
        add_ld(1, al, cl);
        add_rd(6, 10'(cl * 9 + al), 3'(cl), cl[0], 1'b0);
        add_rd(10, 10'(cl * 3), 3'(al), ~cl[0], 1'b1);
        run("R1", 40);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule